// File: doc/BRIEF.md
# Stream to 36-bit word packer

This block turns a continuous bit stream, arriving as 16-bit words on a valid/ready input, into a sequence of 36-bit host words. Each host word leaves as three 16-bit slots on a valid/ready output. The first slot holds host bits 0-15 and the second holds bits 16-31. The third slot holds bits 32-35 in its top nibble and zeros below. The stream is read MSB first within each word. Host bit 0 is the most significant bit of the first slot.

The caller pulses a start input together with a count of host words. The high byte of the first stream word has already been used upstream, so conversion begins at that word's low byte. Because 36 and 16 share a factor of four, the stream position relative to word boundaries cycles through byte, nibble, zero and three-nibble offsets. The pattern repeats every four host words, which take nine stream words and produce twelve slots. The count drops after each host word, so a run may stop at any point within that four-word group. Stream bits left over after the last host word are discarded.

Top module: `sp36_packer`

## Requirements
- R1: While reset is asserted and right after it, out_valid_o, in_ready_o and done_o are 0.
- R2: The first slot of a run begins with bits 7..0 of the first stream word, followed by bits 15..8 of the second stream word. Bits 15..8 of the first stream word never appear in the output.
- R3: Every third slot of a run carries host bits 32-35 in its bits 15..12, with bits 11..0 at zero.
- R4: For any host word index k, the slot bits equal stream bits 8+36k+b, where b is the host bit index. This holds across group boundaries, so nine stream words map to twelve slots and the pattern repeats.
- R5: A start with count N>0 produces exactly 3N output slots, whatever the value of N modulo 4.
- R6: A run of N>0 host words accepts exactly ceil((8+36N)/16) stream words.
- R7: done_o rises after the last slot of a run has been accepted and stays at 1 until the next start. A start with count 0 raises done_o without accepting any stream word or producing any slot.
- R8: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o holds its value, given a stalled input that is held stable.
- R9: A start pulse during a run is ignored, so the run's slot count and consumption stay those of the first count.
- R10: While done_o is 1, out_valid_o and in_ready_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| count_i | input | CNT_W | Number of 36-bit host words for the run |
| in_data_i | input | 16 | Stream word |
| in_valid_i | input | 1 | Stream word valid |
| in_ready_o | output | 1 | Stream word accepted this cycle when valid |
| out_data_o | output | 16 | Output slot |
| out_valid_o | output | 1 | Output slot valid |
| out_ready_i | input | 1 | Output slot accepted |
| done_o | output | 1 | Run finished |

## Verification
The hardest case to reach is a run that ends partway through a four-word group while the input and output stall independently. In that case a third slot can come either from the leftover register alone or from a freshly pulled stream word. The bench sweeps every count from 0 to 9, plus 13, under four stall patterns. It compares each slot against stream bits computed arithmetically and checks the exact number of words consumed. One run receives a second start pulse partway through.

// File: rtl/sp36_pkg.sv
package sp36_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned LEFT_NIBS = 3;
  localparam int unsigned LEFT_W = LEFT_NIBS * NIB_W;
  localparam int unsigned SLOTS_PER_WORD = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } sp36_state_e;
endpackage

// File: rtl/sp36_align.sv
module sp36_align
  import sp36_pkg::*;
(
  input  logic [LEFT_W-1:0] left_i,
  input  logic [1:0]        lcnt_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tail_i,
  output logic [WORD_W-1:0] slot_o,
  output logic              need_word_o,
  output logic [LEFT_W-1:0] next_left_o,
  output logic [1:0]        next_lcnt_o
);
  localparam int unsigned CAT_W = LEFT_W + WORD_W;

  logic [CAT_W-1:0]  cat;
  logic [CAT_W-1:0]  win;
  logic [LEFT_W-1:0] keep_full;
  logic [LEFT_W-1:0] keep_less;
  logic [LEFT_W-1:0] nib_sh;
  logic [1:0]        lcnt_m1;

  always_comb begin
    cat       = {left_i, word_i};
    lcnt_m1   = lcnt_i - 2'd1;
    keep_full = ~({LEFT_W{1'b1}} << (NIB_W * lcnt_i));
    keep_less = ~({LEFT_W{1'b1}} << (NIB_W * lcnt_m1));
    win       = cat >> (NIB_W * lcnt_i);
    nib_sh    = left_i >> (NIB_W * lcnt_m1);
    slot_o      = '0;
    need_word_o = 1'b1;
    next_left_o = left_i;
    next_lcnt_o = lcnt_i;
    if (!tail_i) begin
      slot_o      = win[WORD_W-1:0];
      need_word_o = 1'b1;
      next_left_o = word_i[LEFT_W-1:0] & keep_full;
      next_lcnt_o = lcnt_i;
    end else if (lcnt_i == 2'd0) begin
      slot_o      = {word_i[WORD_W-1 -: NIB_W], {(WORD_W-NIB_W){1'b0}}};
      need_word_o = 1'b1;
      next_left_o = word_i[LEFT_W-1:0];
      next_lcnt_o = 2'(LEFT_NIBS);
    end else begin
      slot_o      = {nib_sh[NIB_W-1:0], {(WORD_W-NIB_W){1'b0}}};
      need_word_o = 1'b0;
      next_left_o = left_i & keep_less;
      next_lcnt_o = lcnt_m1;
    end
  end
endmodule

// File: rtl/sp36_wcount.sv
module sp36_wcount #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load_i || dec_i) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sp36_packer.sv
module sp36_packer
  import sp36_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [15:0]       in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [15:0]       out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              done_o
);
  localparam logic [1:0] TAIL_SLOT = 2'(SLOTS_PER_WORD - 1);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sp36_state_e       state_q, state_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [1:0]        lcnt_q, lcnt_d;
  logic [1:0]        slot_q, slot_d;
  logic              done_q, done_d;

  logic              tail;
  logic [WORD_W-1:0] al_slot;
  logic              al_need;
  logic [LEFT_W-1:0] al_left;
  logic [1:0]        al_lcnt;
  logic              cnt_load;
  logic              cnt_dec;
  logic              cnt_last;
  logic              fire;

  assign tail = (slot_q == TAIL_SLOT);

  sp36_align u_align (
    .left_i      (left_q),
    .lcnt_i      (lcnt_q),
    .word_i      (in_data_i),
    .tail_i      (tail),
    .slot_o      (al_slot),
    .need_word_o (al_need),
    .next_left_o (al_left),
    .next_lcnt_o (al_lcnt)
  );

  sp36_wcount #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_i     (cnt_load),
    .load_val_i (count_i),
    .dec_i      (cnt_dec),
    .last_o     (cnt_last)
  );

  always_comb begin
    state_d     = state_q;
    left_d      = left_q;
    lcnt_d      = lcnt_q;
    slot_d      = slot_q;
    done_d      = done_q;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    cnt_load    = 1'b0;
    cnt_dec     = 1'b0;
    fire        = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_load = 1'b1;
          slot_d   = 2'd0;
          if (count_i == '0) begin
            done_d = 1'b1;
          end else begin
            done_d  = 1'b0;
            state_d = ST_PRIME;
          end
        end
      end
      ST_PRIME: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          left_d  = {{(LEFT_W-8){1'b0}}, in_data_i[7:0]};
          lcnt_d  = 2'd2;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        out_valid_o = !al_need || in_valid_i;
        in_ready_o  = al_need && out_ready_i;
        fire        = out_valid_o && out_ready_i;
        if (fire) begin
          left_d = al_left;
          lcnt_d = al_lcnt;
          slot_d = tail ? 2'd0 : slot_q + 2'd1;
          if (tail) begin
            cnt_dec = 1'b1;
            if (cnt_last) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      lcnt_q  <= '0;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (fire || state_q == ST_PRIME) begin
        left_q <= left_d;
        lcnt_q <= lcnt_d;
      end
      if (fire || (state_q == ST_IDLE && start_i)) slot_q <= slot_d;
    end
  end

  assign out_data_o = al_slot;
  assign done_o     = done_q;
endmodule

// File: rtl/sp36_packer_chk.sv
module sp36_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] out_data_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic        in_ready_o,
  input logic        done_o
);
  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 2'd0;
    else if (out_valid_o && out_ready_i) seen_q <= (seen_q == 2'd2) ? 2'd0 : seen_q + 2'd1;
  end

  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o);

  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> $stable(out_data_o));

  a_r3_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && seen_q == 2'd2 |-> out_data_o[11:0] == 12'd0);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !out_valid_o && !in_ready_o);

  a_r7_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && $past(out_valid_o) |-> $past(out_ready_i) && $past(seen_q) == 2'd2);
endmodule

bind sp36_packer sp36_packer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .in_ready_o  (in_ready_o),
  .done_o      (done_o)
);

// File: tb/tb_sp36_packer.sv
`timescale 1ns/1ps
module tb_sp36_packer;
  localparam int CNT_W = 16;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [CNT_W-1:0] count_i;
  logic [15:0]      in_data_i;
  logic             in_valid_i;
  logic             in_ready_o;
  logic [15:0]      out_data_o;
  logic             out_valid_o;
  logic             out_ready_i;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  bit wd_hit = 0;

  sp36_packer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] gen_word(int i);
    logic [15:0] v;
    v = 16'((i * 40503 + 4660) ^ (i << 7) ^ (i * 9));
    return v;
  endfunction

  function automatic logic [15:0] exp_slot(int k, int s);
    logic [15:0] r;
    r = '0;
    for (int j = 0; j < 16; j++) begin
      if (!(s == 2 && j >= 4)) begin
        int p;
        logic [15:0] w;
        p = 8 + 36 * k + 16 * s + j;
        w = gen_word(p / 16);
        r[15 - j] = w[15 - (p % 16)];
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(int n, int mode, bit restart_mid);
    int idx = 0;
    int oc = 0;
    int cyc = 0;
    bit took = 0;
    bit stall_seen = 0;
    logic [15:0] stall_data = '0;
    int exp_words;
    @(negedge clk);
    start_i = 1'b1;
    count_i = CNT_W'(n);
    @(negedge clk);
    start_i = 1'b0;
    count_i = '0;
    while (!done_o) begin
      bit in_gap, out_gap;
      in_gap  = (mode == 1 || mode == 3) && (cyc % 3 == 1);
      out_gap = (mode == 2 && cyc % 4 == 2) || (mode == 3 && cyc % 5 >= 3);
      if (took || !in_valid_i) begin
        in_valid_i = !in_gap;
        in_data_i  = gen_word(idx);
      end
      out_ready_i = !out_gap;
      start_i = restart_mid && (cyc == 4);
      count_i = restart_mid ? CNT_W'(1) : '0;
      #1;
      if (stall_seen) begin
        check(out_valid_o && out_data_o == stall_data, "R8", {15'd0, out_valid_o, out_data_o}, {16'd1, stall_data});
        stall_seen = 0;
      end
      if (out_valid_o && !out_ready_i) begin
        stall_seen = 1;
        stall_data = out_data_o;
      end
      took = in_valid_i && in_ready_o;
      if (out_valid_o && out_ready_i) begin
        int k, s;
        string tag;
        k = oc / 3;
        s = oc % 3;
        tag = (s == 2) ? "R3" : ((oc == 0) ? "R2" : "R4");
        check(out_data_o == exp_slot(k, s), tag, {16'd0, out_data_o}, {16'd0, exp_slot(k, s)});
        oc++;
      end
      if (took) idx++;
      cyc++;
      if (cyc > 3000) begin
        wd_hit = 1;
        break;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    in_valid_i = 1'b0;
    out_ready_i = 1'b0;
    if (wd_hit) return;
    exp_words = (n == 0) ? 0 : (8 + 36 * n + 15) / 16;
    check(oc == 3 * n, restart_mid ? "R9" : "R5", oc, 3 * n);
    check(idx == exp_words, restart_mid ? "R9" : "R6", idx, exp_words);
    #1;
    check(done_o == 1'b1, "R7", done_o, 1);
    repeat (2) @(negedge clk);
    #1;
    check(done_o && !out_valid_o && !in_ready_o, "R10", {done_o, out_valid_o, in_ready_o}, 3'b100);
    check(done_o == 1'b1, "R7", done_o, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    count_i = '0;
    in_data_i = '0;
    in_valid_i = 1'b0;
    out_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid_o && !in_ready_o && !done_o, "R1", {out_valid_o, in_ready_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid_o && !in_ready_o && !done_o, "R1", {out_valid_o, in_ready_o, done_o}, 0);
    for (int mode = 0; mode < 4 && !wd_hit; mode++) begin
      for (int n = 0; n < 10 && !wd_hit; n++) run(n, mode, 1'b0);
    end
    if (!wd_hit) run(13, 3, 1'b0);
    if (!wd_hit) run(6, 1, 1'b1);
    if (wd_hit) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule